// File: doc/BRIEF.md
# Unsigned Add/Subtract Stage with Condition-Code Carry Chain

This block adds or subtracts two unsigned operands at either a 32-bit or a 64-bit width. The carry or borrow of a multi-word operation travels between steps inside a 2-bit condition code, not in a separate flag bit. To handle a number wider than one word, the caller issues a plain add or subtract on the least significant word. It then issues the carry or borrow form on each higher word, and feeds in the condition code returned by the step before.

Each operation is started by a one-cycle valid strobe. The result and the new condition code are registered and appear one cycle later, together with a one-cycle done pulse. They then stay unchanged until the next valid. Storing the operands and sequencing the words are the caller's job.

Top module: `wide_carry_addsub`

## Requirements
- R1: With opSel = 0 (plain add), the result is A + B modulo 2^width, and ccIn has no effect.
- R2: With opSel = 1 (add with carry), the result is A + B + c modulo 2^width, where c = 1 when ccIn is 2 or 3 and c = 0 when ccIn is 0 or 1.
- R3: With opSel = 2 (plain subtract), the result is A - B modulo 2^width, and ccIn has no effect.
- R4: With opSel = 3 (subtract with borrow), the result is A - B - d modulo 2^width, where d = 1 when ccIn is 0 or 1 and d = 0 when ccIn is 2 or 3.
- R5: After an add (opSel 0 or 1), ccOut is 0 for a zero result with no carry-out, 1 for a nonzero result with no carry-out, 2 for a zero result with carry-out, and 3 for a nonzero result with carry-out.
- R6: After a subtract (opSel 2 or 3), ccOut is 0 for a zero result with a borrow, 1 for a nonzero result with a borrow, 2 for a zero result without a borrow, and 3 for a nonzero result without a borrow.
- R7: With wideSel = 0 (32-bit), only the low 32 bits of A and B are used. Result bits 63:32 are zero, and the carry, borrow and zero test are taken from the 32-bit result. With wideSel = 1 the full 64 bits are used.
- R8: doneOut is high in the cycle after a cycle with validIn high and low otherwise. Without validIn, resultOut and ccOut keep their values.
- R9: While rstN is low, resultOut is 0, ccOut is 0 and doneOut is 0.
- R10: A plain step on the low word followed by a carry or borrow step on the high word, fed with the low step's ccOut, yields the 128-bit sum or difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Start one operation this cycle |
| opSel | input | 2 | 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow |
| wideSel | input | 1 | 1 selects 64-bit, 0 selects 32-bit |
| ccIn | input | 2 | Condition code returned by the previous step |
| aIn | input | 64 | First operand |
| bIn | input | 64 | Second operand (the subtrahend) |
| resultOut | output | 64 | Registered result |
| ccOut | output | 2 | Registered condition code |
| doneOut | output | 1 | One-cycle pulse when the result is ready |

## Verification
The bench builds the block with its defaults: a 64-bit full width and a 32-bit narrow width. Both the carry taken out of bit 31 and the carry taken out of bit 63 can therefore be reached with the same instance. The 32-bit cases load nonzero upper operand bits, so a narrow operation that wrongly uses them shows up in the result. Chains of two 64-bit steps cover 128-bit sums and differences, and these include carries and borrows that run across the whole low word.

// File: rtl/carry_chain_pkg.sv
package carry_chain_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_ADDC = 2'd1,
    OP_SUB  = 2'd2,
    OP_SUBB = 2'd3
  } arith_op_e;

  typedef struct packed {
    logic load;     // capture a new result this cycle
    logic invertB;  // subtract: use ~B
    logic carryIn;  // carry into bit 0
    logic narrow;   // 32-bit operation
  } dp_ctrl_t;
endpackage

// File: rtl/addsub_ctrl.sv
module addsub_ctrl
  import carry_chain_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       validIn,
  input  logic [1:0] opSel,
  input  logic       wideSel,
  input  logic [1:0] ccIn,
  output dp_ctrl_t   strobes,
  output logic       doneOut
);
  arith_op_e opCode;
  logic      chainCarry;

  assign opCode = arith_op_e'(opSel);
  // Codes 2 and 3 mean carry after add and no borrow after subtract:
  // in both cases the carry-in of the adder is 1.
  assign chainCarry = ccIn[1];

  always_comb begin
    strobes.load   = validIn;
    strobes.narrow = !wideSel;
    unique case (opCode)
      OP_ADD:  begin strobes.invertB = 1'b0; strobes.carryIn = 1'b0;       end
      OP_ADDC: begin strobes.invertB = 1'b0; strobes.carryIn = chainCarry; end
      OP_SUB:  begin strobes.invertB = 1'b1; strobes.carryIn = 1'b1;       end
      default: begin strobes.invertB = 1'b1; strobes.carryIn = chainCarry; end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneOut <= 1'b0;
    else       doneOut <= validIn;
  end

  p_done_after_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> doneOut);
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> !doneOut);
endmodule

// File: rtl/addsub_datapath.sv
module addsub_datapath
  import carry_chain_pkg::*;
#(
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctrl_t          strobes,
  input  logic [WIDE_W-1:0] aIn,
  input  logic [WIDE_W-1:0] bIn,
  output logic [WIDE_W-1:0] resultOut,
  output logic [1:0]        ccOut
);
  localparam int PAD_W = WIDE_W - NARROW_W;

  logic [WIDE_W-1:0]   bOperand;
  logic [WIDE_W:0]     sumWide;
  logic [NARROW_W:0]   sumNarrow;
  logic [WIDE_W-1:0]   resNext;
  logic                carryNext;

  assign bOperand = strobes.invertB ? ~bIn : bIn;

  always_comb begin
    sumWide   = {1'b0, aIn} + {1'b0, bOperand} + {{WIDE_W{1'b0}}, strobes.carryIn};
    sumNarrow = {1'b0, aIn[NARROW_W-1:0]} + {1'b0, bOperand[NARROW_W-1:0]}
              + {{NARROW_W{1'b0}}, strobes.carryIn};
  end

  generate
    if (PAD_W > 0) begin : g_pad
      always_comb begin
        if (strobes.narrow) begin
          resNext   = {{PAD_W{1'b0}}, sumNarrow[NARROW_W-1:0]};
          carryNext = sumNarrow[NARROW_W];
        end else begin
          resNext   = sumWide[WIDE_W-1:0];
          carryNext = sumWide[WIDE_W];
        end
      end
    end else begin : g_same
      always_comb begin
        resNext   = sumWide[WIDE_W-1:0];
        carryNext = sumWide[WIDE_W];
      end
    end
  endgenerate

  // Add: carry out. Subtract (A + ~B + 1): carry out means no borrow.
  // Both land in the high code bit; the low bit marks a nonzero result.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultOut <= '0;
      ccOut     <= 2'b00;
    end else if (strobes.load) begin
      resultOut <= resNext;
      ccOut     <= {carryNext, |resNext};
    end
  end

  p_cc_nonzero_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.load) |-> (ccOut[0] == (resultOut != '0)));
  p_narrow_upper_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.load && strobes.narrow) |-> (resultOut[WIDE_W-1:NARROW_W] == '0));
  p_hold_result_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.load) |-> ($stable(resultOut) && $stable(ccOut)));
endmodule

// File: rtl/wide_carry_addsub.sv
module wide_carry_addsub
  import carry_chain_pkg::*;
#(
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic [1:0]        opSel,
  input  logic              wideSel,
  input  logic [1:0]        ccIn,
  input  logic [WIDE_W-1:0] aIn,
  input  logic [WIDE_W-1:0] bIn,
  output logic [WIDE_W-1:0] resultOut,
  output logic [1:0]        ccOut,
  output logic              doneOut
);
  dp_ctrl_t strobes;

  addsub_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .validIn(validIn), .opSel(opSel),
    .wideSel(wideSel), .ccIn(ccIn), .strobes(strobes), .doneOut(doneOut)
  );

  addsub_datapath #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .aIn(aIn), .bIn(bIn),
    .resultOut(resultOut), .ccOut(ccOut)
  );

  p_plain_add_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(validIn && opSel == 2'd0 && wideSel) |-> (resultOut == $past(aIn + bIn)));
  p_add_carry_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(validIn && opSel == 2'd1 && wideSel)
      |-> (resultOut == $past(aIn + bIn + {{(WIDE_W-1){1'b0}}, ccIn[1]})));
  p_plain_sub_r3: assert property (@(posedge clk) disable iff (!rstN)
    $past(validIn && opSel == 2'd2 && wideSel) |-> (resultOut == $past(aIn - bIn)));
  p_reset_quiet_r9: assert property (@(posedge clk)
    !rstN |-> (resultOut == '0 && ccOut == 2'b00 && !doneOut));
endmodule

// File: tb/sim_wide_carry_addsub.sv
`timescale 1ns/1ps
module sim_wide_carry_addsub;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic [1:0]  opSel = 2'd0;
  logic        wideSel = 1'b1;
  logic [1:0]  ccIn = 2'd0;
  logic [63:0] aIn = '0;
  logic [63:0] bIn = '0;
  logic [63:0] resultOut;
  logic [1:0]  ccOut;
  logic        doneOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  logic [63:0] expRes[$];
  logic [1:0]  expCc[$];
  string       expTag[$];
  logic [63:0] lastRes;
  logic [1:0]  lastCc;

  always #10 clk = ~clk;  // 50 MHz

  wide_carry_addsub u0 (
    .clk(clk), .rstN(rstN), .validIn(validIn), .opSel(opSel), .wideSel(wideSel),
    .ccIn(ccIn), .aIn(aIn), .bIn(bIn), .resultOut(resultOut), .ccOut(ccOut),
    .doneOut(doneOut)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference taken from the requirement text.
  task automatic model(input logic [63:0] a, input logic [63:0] b, input logic [1:0] op,
                       input bit wide, input logic [1:0] cci,
                       output logic [63:0] r, output logic [1:0] cc);
    logic [64:0] mask, aa, bb, full;
    logic carry;
    mask = wide ? {1'b0, {64{1'b1}}} : 65'h0_FFFF_FFFF;
    aa = {1'b0, a} & mask;
    bb = {1'b0, b} & mask;
    if (op < 2) begin
      full  = aa + bb + ((op == 2'd1 && cci >= 2) ? 65'd1 : 65'd0);
      carry = wide ? full[64] : full[32];
    end else begin
      logic [64:0] brw;
      brw   = (op == 2'd3 && cci <= 1) ? 65'd1 : 65'd0;
      carry = (aa >= bb + brw);
      full  = aa - bb - brw;
    end
    r  = full[63:0] & mask[63:0];
    cc = {carry, r != 64'd0};
  endtask

  task automatic drive(logic [63:0] a, logic [63:0] b, logic [1:0] op, bit wide,
                       logic [1:0] cci, string tag);
    logic [63:0] r;
    logic [1:0]  cc;
    @(negedge clk);
    aIn = a; bIn = b; opSel = op; wideSel = wide; ccIn = cci; validIn = 1'b1;
    model(a, b, op, wide, cci, r, cc);
    expRes.push_back(r); expCc.push_back(cc); expTag.push_back(tag);
    lastRes = r; lastCc = cc;
  endtask

  task automatic idle();
    @(negedge clk);
    validIn = 1'b0;
  endtask

  // Monitor: compare each done pulse against the scoreboard.
  always @(negedge clk) begin
    if (rstN && doneOut) begin
      if (expRes.size() == 0) begin
        nChecks++; nFails++;
        $display("FAIL R8 unexpected done actual=1 expected=0");
      end else begin
        string t;
        t = expTag.pop_front();
        check({t, " result"}, resultOut, expRes.pop_front());
        check({t, " cc"}, {62'd0, ccOut}, {62'd0, expCc.pop_front()});
      end
    end
  end

  // Two-word chain: low word plain, high word fed with the design's ccOut.
  task automatic chain(logic [127:0] a, logic [127:0] b, bit isSub, string tag);
    logic [63:0] lo, hi;
    logic [127:0] expv;
    drive(a[63:0], b[63:0], isSub ? 2'd2 : 2'd0, 1'b1, 2'd0, {tag, " low"});
    @(negedge clk);
    lo = resultOut;
    aIn = a[127:64]; bIn = b[127:64]; opSel = isSub ? 2'd3 : 2'd1; ccIn = ccOut;
    begin
      logic [63:0] r; logic [1:0] cc;
      model(a[127:64], b[127:64], opSel, 1'b1, expCc[0], r, cc);
      expRes.push_back(r); expCc.push_back(cc); expTag.push_back({tag, " high"});
    end
    @(negedge clk);
    validIn = 1'b0;
    hi = resultOut;
    expv = isSub ? a - b : a + b;
    check({tag, " 128-bit"}, hi, expv[127:64]);
    check({tag, " 128-bit low"}, lo, expv[63:0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset result", resultOut, 64'd0);
    check("R9 reset cc", {62'd0, ccOut}, 64'd0);
    check("R9 reset done", {63'd0, doneOut}, 64'd0);
    rstN = 1'b1;

    drive(64'd5, 64'd7, 2'd0, 1'b1, 2'd3, "R1 R5 add ignores cc");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 2'd0, 1'b1, 2'd2, "R1 R5 add wraps to zero");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 2'd0, 1'b1, 2'd0, "R5 carry nonzero");
    drive(64'd10, 64'd20, 2'd1, 1'b1, 2'd2, "R2 carry in from cc2");
    drive(64'd10, 64'd20, 2'd1, 1'b1, 2'd1, "R2 no carry from cc1");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 2'd1, 1'b1, 2'd3, "R2 R5 carry ripples");
    drive(64'd10, 64'd3, 2'd2, 1'b1, 2'd0, "R3 R6 sub ignores cc");
    drive(64'd3, 64'd10, 2'd2, 1'b1, 2'd3, "R3 R6 sub borrow");
    drive(64'd42, 64'd42, 2'd2, 1'b1, 2'd1, "R6 sub equal zero");
    drive(64'd10, 64'd3, 2'd3, 1'b1, 2'd1, "R4 borrow from cc1");
    drive(64'd10, 64'd3, 2'd3, 1'b1, 2'd3, "R4 no borrow from cc3");
    drive(64'd0, 64'd0, 2'd3, 1'b1, 2'd0, "R4 R6 zero minus borrow");
    drive(64'd1, 64'd0, 2'd3, 1'b1, 2'd0, "R4 R6 zero result with borrow-in");
    drive(64'hDEAD_BEEF_FFFF_FFFF, 64'h1234_0000_0000_0001, 2'd0, 1'b0, 2'd0, "R7 narrow add carry");
    drive(64'hAAAA_0000_0000_0005, 64'h5555_0000_0000_0009, 2'd2, 1'b0, 2'd0, "R7 narrow sub borrow");
    drive(64'hFFFF_FFFF_7FFF_FFFF, 64'h0, 2'd1, 1'b0, 2'd2, "R7 narrow add with carry");
    idle();
    @(negedge clk);
    check("R8 done drops", {63'd0, doneOut}, 64'd0);
    check("R8 result held", resultOut, lastRes);
    check("R8 cc held", {62'd0, ccOut}, {62'd0, lastCc});

    chain({64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF}, 128'd1, 1'b0, "R10 add chain");
    chain({64'h0000_0000_0000_0002, 64'h0}, 128'd1, 1'b1, "R10 sub chain");
    chain({64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321},
          {64'h0000_0000_0000_0001, 64'hFFFF_0000_0000_0000}, 1'b1, "R10 sub chain mixed");
    repeat (2) @(negedge clk);
    if (expRes.size() != 0) begin
      nChecks++; nFails++;
      $display("FAIL R8 missing done actual=%0d expected=0", expRes.size());
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule